// File: doc/BRIEF.md
# Gray-Scale PWM Output Gate

This block decides, on every cycle, which of a row of print-head dots is driven. A 4-bit level counter advances once per rising edge of a counter clock strobe and cycles through sixteen values. It is compared against a 4-bit duty code taken from the low nibble of the data bus. Each dot whose pattern bit is set is driven while the count is below the code. The top code is a special case and drives the dot for the whole period. This gives sixteen gray levels from fully off to fully on.

A second path gives a global enable. A requested enable level takes effect only on a rising edge of a separate enable clock strobe, and only while that strobe's gate input is high. An inhibit input models the external burn-out protection and turns every dot off. A force-on input turns every dot on and overrides all of the gating above. Reset overrides everything and turns every dot off.

All strobes are sampled in the `clk` domain. The drive outputs are registered, so every gating term shows at the outputs one clock after it is registered internally.

Top module: `gs_pwm_gate`

## Requirements
- R1: The level counter is 4 bits wide and starts at 0 after reset. It advances by one, wrapping from 15 to 0, in the clock cycle that sees a rising edge on `cnt_clk_i`, and it holds otherwise.
- R2: The duty register loads `duty_bus_i` on every clock while `duty_load_n_i` is low. It holds its value while `duty_load_n_i` is high, and it is 0 after reset.
- R3: In gray-scale mode a set dot is driven while the count is below the duty code. Codes 0 to 14 therefore give that many driven counts out of 16, and code 15 (4'hF) drives the dot for all 16 counts.
- R4: While `pwm_n_i` is high, the duty compare is bypassed. Set dots are then gated only by the enable and the inhibit.
- R5: The enable state is off after reset. A gated rising edge of `en_clk_i` turns it off when `en_level_i` is high and on when `en_level_i` is low. A change of `en_level_i` alone has no effect until that edge.
- R6: A rising edge of `en_clk_i` has no effect on the enable state while `en_clk_gate_i` is low.
- R7: While `inhibit_i` is high and force-on is inactive, all drive outputs are 0.
- R8: While `force_on_n_i` is low (and reset is inactive), all drive outputs are 1, whatever the pattern, the enable, the inhibit and the duty compare.
- R9: While reset is asserted, all drive outputs are 0, even with force-on active. Counter, duty and enable state return to their reset values.
- R10: A drive bit with a clear pattern bit is 0 unless force-on is active. Outputs follow the registered gating terms with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dot_i | input | 48 | Dot pattern, 1 = dot requested |
| cnt_clk_i | input | 1 | Counter clock strobe; a rising edge advances the level counter |
| duty_bus_i | input | 4 | Low nibble of the data bus carrying the duty code |
| duty_load_n_i | input | 1 | Active-low duty load; the duty register follows the bus while low |
| pwm_n_i | input | 1 | Low selects gray-scale mode, high bypasses the compare |
| en_clk_i | input | 1 | Enable clock strobe; a rising edge applies the enable level |
| en_clk_gate_i | input | 1 | High lets enable clock edges through |
| en_level_i | input | 1 | Requested enable level: high = outputs off, low = outputs on |
| force_on_n_i | input | 1 | Active-low force of every output on |
| inhibit_i | input | 1 | High inhibits every output (protection one-shot) |
| drive_o | output | 48 | Registered dot drive, 1 = on |

## Verification
The bound checker watches on every cycle that the counter only ever steps by one with wrap, that the duty register is frozen while its load is high, and that the enable state changes only after a gated enable clock edge. It also checks that reset, inhibit, force-on and the full-on code 15 give the output words they must. The exact duty fraction of each code, the claim that a level change waits for the next enable edge, and the mixing of pattern, mode and control inputs are shown only by the bench. It counts driven counts over full counter periods and compares random sequences against a bench model.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

  // Width of the gray-scale level counter and of the duty code.
  localparam int unsigned LEVEL_W = 4;

  typedef logic [LEVEL_W-1:0] level_t;

  // The code that means "on for the whole period".
  localparam level_t LEVEL_FULL = '1;

  // Gating terms shared by every dot lane.
  typedef struct packed {
    logic force_on;  // drive every lane
    logic open;      // enabled and not inhibited
    logic pwm_pass;  // duty compare passes, or compare bypassed
  } gate_ctl_t;

  // Duty compare with the irregular top code.
  function automatic logic level_hit(input level_t cnt, input level_t duty);
    return (cnt < duty) || (duty == LEVEL_FULL);
  endfunction

endpackage

// File: rtl/gs_rst_sync.sv
module gs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/gs_rise_det.sv
module gs_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/gs_level_cnt.sv
module gs_level_cnt
  import gs_pwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_i,
  input  level_t duty_bus_i,
  input  logic   duty_load_n_i,
  output level_t cnt_o,
  output level_t duty_o,
  output logic   hit_o
);

  level_t cnt_q, cnt_d;
  level_t duty_q, duty_d;
  logic   cnt_en;
  logic   duty_en;

  assign cnt_en  = step_i;
  assign duty_en = ~duty_load_n_i;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + level_t'(1);
    end
  end

  always_comb begin
    duty_d = duty_q;
    if (duty_en) begin
      duty_d = duty_bus_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign hit_o  = level_hit(cnt_q, duty_q);

endmodule

// File: rtl/gs_enable_sync.sv
module gs_enable_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic eclk_rise_i,
  input  logic gate_i,
  input  logic level_i,
  output logic en_o
);

  logic en_q, en_d;
  logic upd;

  assign upd = eclk_rise_i & gate_i;

  always_comb begin
    en_d = en_q;
    if (upd) begin
      en_d = ~level_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/gs_dot_gate.sv
module gs_dot_gate
  import gs_pwm_pkg::*;
#(
  parameter int unsigned DOTS = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DOTS-1:0] dot_i,
  input  gate_ctl_t       ctl_i,
  output logic [DOTS-1:0] drive_o
);

  logic [DOTS-1:0] lane_d;
  logic [DOTS-1:0] drive_q;

  for (genvar i = 0; i < DOTS; i++) begin : g_lane
    assign lane_d[i] = ctl_i.force_on | (dot_i[i] & ctl_i.open & ctl_i.pwm_pass);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
    end else begin
      drive_q <= lane_d;
    end
  end

  assign drive_o = drive_q;

endmodule

// File: rtl/gs_pwm_gate.sv
module gs_pwm_gate
  import gs_pwm_pkg::*;
#(
  parameter int unsigned DOTS       = 48,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DOTS-1:0] dot_i,
  input  logic            cnt_clk_i,
  input  logic [3:0]      duty_bus_i,
  input  logic            duty_load_n_i,
  input  logic            pwm_n_i,
  input  logic            en_clk_i,
  input  logic            en_clk_gate_i,
  input  logic            en_level_i,
  input  logic            force_on_n_i,
  input  logic            inhibit_i,
  output logic [DOTS-1:0] drive_o
);

  logic      rst_sync_n;
  logic      cnt_rise;
  logic      en_rise;
  level_t    cnt;
  level_t    duty;
  logic      hit;
  logic      en_state;
  gate_ctl_t ctl;

  gs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gs_rise_det u_cnt_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_i  (cnt_clk_i),
    .rise_o (cnt_rise)
  );

  gs_rise_det u_en_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_i  (en_clk_i),
    .rise_o (en_rise)
  );

  gs_level_cnt u_level (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .step_i        (cnt_rise),
    .duty_bus_i    (level_t'(duty_bus_i)),
    .duty_load_n_i (duty_load_n_i),
    .cnt_o         (cnt),
    .duty_o        (duty),
    .hit_o         (hit)
  );

  gs_enable_sync u_enable (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .eclk_rise_i (en_rise),
    .gate_i      (en_clk_gate_i),
    .level_i     (en_level_i),
    .en_o        (en_state)
  );

  always_comb begin
    ctl.force_on = ~force_on_n_i;
    ctl.open     = en_state & ~inhibit_i;
    ctl.pwm_pass = pwm_n_i | hit;
  end

  gs_dot_gate #(.DOTS(DOTS)) u_gate (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dot_i   (dot_i),
    .ctl_i   (ctl),
    .drive_o (drive_o)
  );

endmodule

// File: rtl/gs_pwm_gate_chk.sv
module gs_pwm_gate_chk
  import gs_pwm_pkg::*;
#(
  parameter int unsigned DOTS = 48
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic [DOTS-1:0] dot_i,
  input logic            duty_load_n_i,
  input logic            pwm_n_i,
  input logic            en_clk_i,
  input logic            en_clk_gate_i,
  input logic            force_on_n_i,
  input logic            inhibit_i,
  input logic [DOTS-1:0] drive_o,
  input level_t          cnt,
  input level_t          duty,
  input logic            en_state
);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt != $past(cnt)) |-> (cnt == level_t'($past(cnt) + level_t'(1))));

  assert_duty_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    duty_load_n_i |=> $stable(duty));

  assert_full_code_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (force_on_n_i && en_state && !inhibit_i && !pwm_n_i && duty == LEVEL_FULL)
      |=> (drive_o == $past(dot_i)));

  assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (force_on_n_i && !pwm_n_i && duty == '0) |=> (drive_o == '0));

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (force_on_n_i && en_state && !inhibit_i && pwm_n_i) |=> (drive_o == $past(dot_i)));

  assert_disabled_off_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (force_on_n_i && !en_state) |=> (drive_o == '0));

  assert_gated_edge_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(en_state) |-> $past(en_clk_gate_i && en_clk_i));

  assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (force_on_n_i && inhibit_i) |=> (drive_o == '0));

  assert_force_on_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !force_on_n_i |=> (drive_o == '1));

  assert_reset_off_R9: assert property (@(posedge clk)
    !rst_sync_n |-> (drive_o == '0 && cnt == '0 && !en_state));

endmodule

bind gs_pwm_gate gs_pwm_gate_chk #(.DOTS(DOTS)) chk_i (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .dot_i         (dot_i),
  .duty_load_n_i (duty_load_n_i),
  .pwm_n_i       (pwm_n_i),
  .en_clk_i      (en_clk_i),
  .en_clk_gate_i (en_clk_gate_i),
  .force_on_n_i  (force_on_n_i),
  .inhibit_i     (inhibit_i),
  .drive_o       (drive_o),
  .cnt           (cnt),
  .duty          (duty),
  .en_state      (en_state)
);

// File: tb/gs_pwm_gate_tb_top.sv
module gs_pwm_gate_tb_top;

  localparam int DOTS = 48;
  localparam int WATCHDOG = 100000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b1;
  logic [DOTS-1:0] dot_i = '1;
  logic            cnt_clk_i = 1'b0;
  logic [3:0]      duty_bus_i = 4'h0;
  logic            duty_load_n_i = 1'b1;
  logic            pwm_n_i = 1'b0;
  logic            en_clk_i = 1'b0;
  logic            en_clk_gate_i = 1'b0;
  logic            en_level_i = 1'b0;
  logic            force_on_n_i = 1'b1;
  logic            inhibit_i = 1'b0;
  logic [DOTS-1:0] drive_o;

  // bench model state
  logic [3:0] cnt_m = 4'h0;
  logic [3:0] duty_m = 4'h0;
  logic       en_m = 1'b0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gs_pwm_gate #(.DOTS(DOTS)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .dot_i         (dot_i),
    .cnt_clk_i     (cnt_clk_i),
    .duty_bus_i    (duty_bus_i),
    .duty_load_n_i (duty_load_n_i),
    .pwm_n_i       (pwm_n_i),
    .en_clk_i      (en_clk_i),
    .en_clk_gate_i (en_clk_gate_i),
    .en_level_i    (en_level_i),
    .force_on_n_i  (force_on_n_i),
    .inhibit_i     (inhibit_i),
    .drive_o       (drive_o)
  );

  function automatic logic [DOTS-1:0] exp_drive();
    if (!force_on_n_i) return '1;
    if (!en_m || inhibit_i) return '0;
    if (!pwm_n_i && !((cnt_m < duty_m) || (duty_m == 4'hF))) return '0;
    return dot_i;
  endfunction

  task automatic check_vec(input string req, input logic [DOTS-1:0] act,
                           input logic [DOTS-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tick_cnt();
    @(negedge clk) cnt_clk_i = 1'b1;
    @(negedge clk) cnt_clk_i = 1'b0;
    cnt_m = cnt_m + 4'h1;
    @(negedge clk);
  endtask

  task automatic load_duty(input logic [3:0] v);
    @(negedge clk) begin duty_bus_i = v; duty_load_n_i = 1'b0; end
    @(negedge clk) duty_load_n_i = 1'b1;
    duty_m = v;
    @(negedge clk);
  endtask

  task automatic en_pulse(input logic gate, input logic level);
    @(negedge clk) begin en_clk_gate_i = gate; en_level_i = level; en_clk_i = 1'b1; end
    @(negedge clk) en_clk_i = 1'b0;
    if (gate) en_m = ~level;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #1 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_vec("R9 reset state", drive_o, '0);

    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_vec("R5 off after reset", drive_o, '0);

    // enable, gray-scale mode with duty 0
    en_pulse(1'b1, 1'b0);
    check_vec("R3 code 0 off", drive_o, exp_drive());
    @(negedge clk) pwm_n_i = 1'b1;
    @(negedge clk);
    check_vec("R4 bypass", drive_o, dot_i);
    @(negedge clk) pwm_n_i = 1'b0;

    // duty table over full periods
    for (int c = 0; c < 16; c++) begin
      int on_cnt;
      on_cnt = 0;
      load_duty(4'(c));
      for (int k = 0; k < 16; k++) begin
        tick_cnt();
        if (drive_o[0]) on_cnt++;
        if (drive_o !== exp_drive()) begin
          fails++;
          $display("FAIL R3 code %0d count %0d actual=%h expected=%h",
                   c, cnt_m, drive_o, exp_drive());
        end
      end
      check_int($sformatf("R3 R1 duty code %0d", c), on_cnt, (c == 15) ? 16 : c);
    end

    // duty hold while load is high
    load_duty(4'hF);
    @(negedge clk) duty_bus_i = 4'h0;
    settle();
    check_vec("R2 duty held", drive_o, '1);

    // enable path
    @(negedge clk) begin en_level_i = 1'b1; en_clk_gate_i = 1'b1; end
    settle();
    check_vec("R5 level alone no effect", drive_o, '1);
    en_pulse(1'b0, 1'b1);
    check_vec("R6 ungated edge ignored", drive_o, '1);
    en_pulse(1'b1, 1'b1);
    check_vec("R5 gated edge turns off", drive_o, '0);
    en_pulse(1'b1, 1'b0);
    check_vec("R5 gated edge turns on", drive_o, '1);

    // inhibit and force-on
    @(negedge clk) inhibit_i = 1'b1;
    @(negedge clk);
    check_vec("R7 inhibit", drive_o, '0);
    @(negedge clk) begin force_on_n_i = 1'b0; dot_i = '0; end
    @(negedge clk);
    check_vec("R8 force over inhibit and blank", drive_o, '1);
    @(negedge clk) begin force_on_n_i = 1'b1; inhibit_i = 1'b0; dot_i = 48'hA5A5_0F0F_3C3C; end
    @(negedge clk);
    check_vec("R10 pattern passes", drive_o, 48'hA5A5_0F0F_3C3C);

    // reset beats force-on
    @(negedge clk) begin force_on_n_i = 1'b0; rst_n = 1'b0; end
    @(negedge clk);
    check_vec("R9 reset over force", drive_o, '0);
    cnt_m = 4'h0; duty_m = 4'h0; en_m = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_vec("R8 force after reset", drive_o, '1);
    @(negedge clk) force_on_n_i = 1'b1;
    @(negedge clk);
    check_vec("R5 enable cleared by reset", drive_o, '0);
    en_pulse(1'b1, 1'b0);
    load_duty(4'h1);
    check_vec("R1 counter at 0 after reset", drive_o, exp_drive());
    tick_cnt();
    check_vec("R1 counter advanced", drive_o, '0);

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 6)
        0: begin
          @(negedge clk) dot_i = {16'($urandom), 32'($urandom)};
          @(negedge clk);
        end
        1: tick_cnt();
        2: load_duty(4'($urandom));
        3: en_pulse(1'($urandom), ($urandom % 3) == 0);
        4: begin
          @(negedge clk) begin
            inhibit_i    = ($urandom % 5) == 0;
            pwm_n_i      = ($urandom % 4) == 0;
            force_on_n_i = ($urandom % 8) != 0;
          end
          @(negedge clk);
        end
        default: tick_cnt();
      endcase
      check_vec("R10 random mix", drive_o, exp_drive());
    end

    done = 1'b1;
    finish_run();
  end

endmodule